// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the write side of a parallel NOR-style flash interface. It watches bus write cycles and decodes the command bytes they carry. It supports single-write commands and sequences of two and five writes. When a program or erase sequence completes, it sends a one-cycle start request to the program/erase controller. The request carries an operation code, a target address and a data word. One-cycle pulses request status clear, suspend and resume.

The decoder also keeps the sticky read mode: array, status or signature. It steers bus read data from the array, from the status register or from a fixed pair of identification codes. Some commands are accepted only in certain conditions. Quad-byte program and chip erase require the multiplexed-address mode input. A busy controller narrows the accepted commands. A suspended operation blocks new erases.

A write is taken on a rising clock edge while `wr_en_i` is high. Every registered output reflects that write from the same edge onward.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A single write of FFh, 70h, 90h or 98h from idle sets `rd_sel_o` to 0 (array), 1 (status), 2 (signature) and 2 respectively. `rd_data_o` returns `arr_data_i` in array mode and `stat_data_i` in status mode.
- R2: In signature mode, `rd_data_o` returns MFR_CODE when `sig_idx_i` is 0 and DEV_CODE when it is 1. Every write other than FFh is ignored in this mode, and FFh returns to array mode.
- R3: A write of 40h or 10h followed by any write raises `start_o` for one cycle with `op_o`=1. `op_addr_o` is the second write's address, and `op_data_o` holds the second write's byte in bits 7:0 with zeros above.
- R4: The pair 20h then D0h starts `op_o`=2 with `op_addr_o` set to the second write's address. The pair 80h then 10h starts `op_o`=3.
- R5: If the second write of a 20h or 80h sequence carries a different byte, nothing starts. The decoder is then idle and decodes the next write as a new command.
- R6: 30h followed by four writes to addresses base+0..base+3 starts `op_o`=4. Here base has bits 1:0 equal to zero. `op_addr_o` is the base, and `op_data_o` bits 8k+7:8k hold the byte written to base+k.
- R7: If any of the four quad writes has the wrong low address bits or a different aligned group, nothing starts and `seq_err_o` goes to 1. It stays at 1 until a 50h write clears it.
- R8: 30h and 80h are ignored while `mux_mode_i` is 0.
- R9: A write of 50h pulses `clr_status_o` for one cycle. The reserved bytes 00h, 01h, 60h, 2Fh and C0h, and any other undefined byte, change no output.
- R10: A start moves `rd_sel_o` to status, and it stays there until a read-mode command is written.
- R11: While `busy_i` is 1, only 70h (status mode) and B0h (one-cycle `suspend_o`, operation marked suspended) are accepted. B0h while not busy is ignored.
- R12: While suspended and not busy, D0h alone pulses `resume_o`, sets status mode and clears the suspension. While suspended, 20h, 80h and 30h are ignored, but a program sequence still starts. D0h when not suspended is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Bus write strobe, one cycle per write |
| wr_addr_i | input | AW | Write address |
| wr_data_i | input | 8 | Write data / command byte |
| mux_mode_i | input | 1 | Multiplexed-address mode is active |
| busy_i | input | 1 | Program/erase controller busy |
| arr_data_i | input | 8 | Array read data |
| stat_data_i | input | 8 | Status register value |
| sig_idx_i | input | 1 | Signature read index (0 manufacturer, 1 device) |
| rd_sel_o | output | 2 | Read source: 0 array, 1 status, 2 signature |
| rd_data_o | output | 8 | Read data steered from the selected source |
| start_o | output | 1 | One-cycle start request |
| op_o | output | 3 | Operation: 1 program, 2 block erase, 3 chip erase, 4 quad program |
| op_addr_o | output | AW | Operation address |
| op_data_o | output | 32 | Operation data |
| suspend_o | output | 1 | One-cycle suspend request |
| resume_o | output | 1 | One-cycle resume request |
| clr_status_o | output | 1 | One-cycle status-clear request |
| seq_err_o | output | 1 | Sticky quad-sequence error |

## Verification
A sequence state that does not return to idle is not visible at once. It shows up on the next write, which is then consumed as a second byte instead of being decoded. So each case is followed by a 70h or FFh write, and the read mode is checked one edge later. A wrong read-mode or suspension flag shows up in the accepted-command pattern of the very next write. That is why every byte value is swept both from idle and while busy. Quad assembly faults appear as a wrong byte lane in `op_data_o` on the edge of the fourth write.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef enum logic [1:0] {RD_ARRAY = 2'd0, RD_STATUS = 2'd1, RD_SIGN = 2'd2} rd_src_e;
  typedef enum logic [2:0] {
    OP_NONE = 3'd0, OP_PROG = 3'd1, OP_BLK_ERASE = 3'd2, OP_CHIP_ERASE = 3'd3, OP_QUAD = 3'd4
  } op_e;
  typedef enum logic [2:0] {S_IDLE, S_PROG, S_BERASE, S_CERASE, S_QUAD} seq_e;

  localparam logic [7:0] C_RD_ARRAY = 8'hFF;
  localparam logic [7:0] C_RD_STAT  = 8'h70;
  localparam logic [7:0] C_RD_SIG_A = 8'h90;
  localparam logic [7:0] C_RD_SIG_B = 8'h98;
  localparam logic [7:0] C_PROG_A   = 8'h40;
  localparam logic [7:0] C_PROG_B   = 8'h10;
  localparam logic [7:0] C_QUAD     = 8'h30;
  localparam logic [7:0] C_CERASE   = 8'h80;
  localparam logic [7:0] C_CE_CONF  = 8'h10;
  localparam logic [7:0] C_BERASE   = 8'h20;
  localparam logic [7:0] C_CONFIRM  = 8'hD0;
  localparam logic [7:0] C_CLR_STAT = 8'h50;
  localparam logic [7:0] C_SUSPEND  = 8'hB0;
endpackage

// File: rtl/fcd_quad_chk.sv
module fcd_quad_chk #(
  parameter int AW = 20
) (
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    idx_i,
  input  logic [AW-3:0] base_i,
  output logic          ok_o
);
  // first write fixes the group; later writes must stay in it at the next lane
  always_comb begin
    ok_o = (addr_i[1:0] == idx_i);
    if (idx_i != 2'd0 && addr_i[AW-1:2] != base_i) ok_o = 1'b0;
  end
endmodule

// File: rtl/fcd_read_mux.sv
module fcd_read_mux
  import fcd_pkg::*;
#(
  parameter logic [7:0] MFR_CODE = 8'hA5,
  parameter logic [7:0] DEV_CODE = 8'h5A
) (
  input  rd_src_e    sel_i,
  input  logic [7:0] arr_data_i,
  input  logic [7:0] stat_data_i,
  input  logic       sig_idx_i,
  output logic [7:0] data_o
);
  always_comb begin
    unique case (sel_i)
      RD_STATUS: data_o = stat_data_i;
      RD_SIGN:   data_o = sig_idx_i ? DEV_CODE : MFR_CODE;
      default:   data_o = arr_data_i;
    endcase
  end
endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
  import fcd_pkg::*;
#(
  parameter int AW = 20,
  localparam int OW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  input  logic          mux_mode_i,
  input  logic          busy_i,
  output rd_src_e       rd_sel_o,
  output logic          start_o,
  output op_e           op_o,
  output logic [AW-1:0] op_addr_o,
  output logic [OW-1:0] op_data_o,
  output logic          suspend_o,
  output logic          resume_o,
  output logic          clr_status_o,
  output logic          seq_err_o
);
  seq_e          state_q;
  rd_src_e       rd_q;
  logic          susp_q;
  logic [1:0]    qidx_q;
  logic          qerr_q;
  logic [AW-3:0] qbase_q;
  logic [OW-1:0] qbuf_q, quad_word;
  logic          quad_ok, quad_bad;

  fcd_quad_chk #(.AW(AW)) u_qchk (
    .addr_i(wr_addr_i), .idx_i(qidx_q), .base_i(qbase_q), .ok_o(quad_ok)
  );

  always_comb begin
    quad_word = qbuf_q;
    quad_word[8*qidx_q +: 8] = wr_data_i;
  end
  assign quad_bad = qerr_q | ~quad_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;  rd_q <= RD_ARRAY;  susp_q <= 1'b0;
      qidx_q <= '0;  qerr_q <= 1'b0;  qbase_q <= '0;  qbuf_q <= '0;
      start_o <= 1'b0;  op_o <= OP_NONE;  op_addr_o <= '0;  op_data_o <= '0;
      suspend_o <= 1'b0;  resume_o <= 1'b0;  clr_status_o <= 1'b0;  seq_err_o <= 1'b0;
    end else begin
      start_o <= 1'b0;  suspend_o <= 1'b0;  resume_o <= 1'b0;  clr_status_o <= 1'b0;
      if (wr_en_i) begin
        unique case (state_q)
          S_IDLE: begin
            if (rd_q == RD_SIGN) begin
              if (wr_data_i == C_RD_ARRAY) rd_q <= RD_ARRAY;
            end else if (busy_i) begin
              if (wr_data_i == C_RD_STAT) rd_q <= RD_STATUS;
              if (wr_data_i == C_SUSPEND) begin
                suspend_o <= 1'b1;
                susp_q    <= 1'b1;
              end
            end else begin
              unique case (wr_data_i)
                C_RD_ARRAY:             rd_q <= RD_ARRAY;
                C_RD_STAT:              rd_q <= RD_STATUS;
                C_RD_SIG_A, C_RD_SIG_B: rd_q <= RD_SIGN;
                C_CLR_STAT: begin
                  clr_status_o <= 1'b1;
                  seq_err_o    <= 1'b0;
                end
                C_PROG_A, C_PROG_B: state_q <= S_PROG;
                C_BERASE: if (!susp_q) state_q <= S_BERASE;
                C_CERASE: if (!susp_q && mux_mode_i) state_q <= S_CERASE;
                C_QUAD: if (!susp_q && mux_mode_i) begin
                  state_q <= S_QUAD;
                  qidx_q  <= '0;
                  qerr_q  <= 1'b0;
                end
                C_CONFIRM: if (susp_q) begin
                  resume_o <= 1'b1;
                  susp_q   <= 1'b0;
                  rd_q     <= RD_STATUS;
                end
                default: ;
              endcase
            end
          end
          S_PROG: begin
            start_o   <= 1'b1;  op_o <= OP_PROG;
            op_addr_o <= wr_addr_i;
            op_data_o <= {{(OW-8){1'b0}}, wr_data_i};
            rd_q      <= RD_STATUS;
            state_q   <= S_IDLE;
          end
          S_BERASE: begin
            if (wr_data_i == C_CONFIRM) begin
              start_o   <= 1'b1;  op_o <= OP_BLK_ERASE;
              op_addr_o <= wr_addr_i;  op_data_o <= '0;
              rd_q      <= RD_STATUS;
            end
            state_q <= S_IDLE;
          end
          S_CERASE: begin
            if (wr_data_i == C_CE_CONF) begin
              start_o   <= 1'b1;  op_o <= OP_CHIP_ERASE;
              op_addr_o <= '0;  op_data_o <= '0;
              rd_q      <= RD_STATUS;
            end
            state_q <= S_IDLE;
          end
          S_QUAD: begin
            qbuf_q <= quad_word;
            qerr_q <= quad_bad;
            if (qidx_q == 2'd0) qbase_q <= wr_addr_i[AW-1:2];
            if (qidx_q == 2'd3) begin
              state_q <= S_IDLE;
              if (quad_bad) begin
                seq_err_o <= 1'b1;
              end else begin
                start_o   <= 1'b1;  op_o <= OP_QUAD;
                op_addr_o <= {qbase_q, 2'b00};
                op_data_o <= quad_word;
                rd_q      <= RD_STATUS;
              end
            end else begin
              qidx_q <= qidx_q + 2'd1;
            end
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  assign rd_sel_o = rd_q;

  AST_START_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(wr_en_i)); // R3
  AST_START_READS_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> rd_q == RD_STATUS); // R10
  AST_SIGN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_q == RD_SIGN && !(wr_en_i && wr_data_i == C_RD_ARRAY)) |=> rd_q == RD_SIGN); // R2
  AST_QUAD_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && op_o == OP_QUAD) |-> op_addr_o[1:0] == 2'b00); // R6
  AST_ERR_FROM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(seq_err_o) |-> $past(wr_en_i) && !start_o); // R7
  AST_RESUME_AFTER_SUSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |-> $past(susp_q) && !susp_q); // R12
  AST_SUSPEND_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspend_o |-> $past(busy_i)); // R11
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int         AW       = 20,
  parameter logic [7:0] MFR_CODE = 8'hA5,
  parameter logic [7:0] DEV_CODE = 8'h5A
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  input  logic          mux_mode_i,
  input  logic          busy_i,
  input  logic [7:0]    arr_data_i,
  input  logic [7:0]    stat_data_i,
  input  logic          sig_idx_i,
  output logic [1:0]    rd_sel_o,
  output logic [7:0]    rd_data_o,
  output logic          start_o,
  output logic [2:0]    op_o,
  output logic [AW-1:0] op_addr_o,
  output logic [31:0]   op_data_o,
  output logic          suspend_o,
  output logic          resume_o,
  output logic          clr_status_o,
  output logic          seq_err_o
);
  rd_src_e rd_sel;
  op_e     op;

  fcd_seq_fsm #(.AW(AW)) u_fsm (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .mux_mode_i, .busy_i,
    .rd_sel_o(rd_sel), .start_o, .op_o(op), .op_addr_o, .op_data_o,
    .suspend_o, .resume_o, .clr_status_o, .seq_err_o
  );

  fcd_read_mux #(.MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_rmux (
    .sel_i(rd_sel), .arr_data_i, .stat_data_i, .sig_idx_i, .data_o(rd_data_o)
  );

  assign rd_sel_o = rd_sel;
  assign op_o     = op;
endmodule

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;
  localparam int AW = 20;
  localparam logic [7:0] MFR = 8'hA5, DEV = 8'h5A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, mux = 1'b0, busy = 1'b0, sig_idx = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0, arr_d = 8'h3C, stat_d = 8'hC3;
  logic [1:0] rd_sel;
  logic [7:0] rd_data;
  logic start, susp, res, clr, serr;
  logic [2:0] op;
  logic [AW-1:0] op_addr;
  logic [31:0] op_data;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  flash_cmd_decoder #(.AW(AW), .MFR_CODE(MFR), .DEV_CODE(DEV)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .mux_mode_i(mux), .busy_i(busy), .arr_data_i(arr_d), .stat_data_i(stat_d),
    .sig_idx_i(sig_idx), .rd_sel_o(rd_sel), .rd_data_o(rd_data), .start_o(start),
    .op_o(op), .op_addr_o(op_addr), .op_data_o(op_data), .suspend_o(susp),
    .resume_o(res), .clr_status_o(clr), .seq_err_o(serr)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int exp_mode(input int c);
    if (c == 'hFF) return 0;
    if (c == 'h70) return 1;
    if (c == 'h90 || c == 'h98) return 2;
    return 0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset rd_sel", rd_sel, 0);
    chk("R3 reset start", start, 0);
    chk("R7 reset seq_err", serr, 0);

    // sweep every byte from idle, not busy, mux off
    for (int c = 0; c < 256; c++) begin
      wr(0, 8'hFF);
      wr(AW'(c), 8'(c));
      chk("R1 sweep rd_sel", rd_sel, exp_mode(c));
      chk("R9 sweep clr", clr, c == 'h50);
      chk("R9 sweep start", start, 0);
      chk("R12 sweep resume", res, 0);
      chk("R11 sweep suspend", susp, 0);
      if (c == 'h40 || c == 'h10) begin
        wr(AW'(c * 5 + 1), 8'(c ^ 'h5A));
        chk("R3 prog start", start, 1);
        chk("R3 prog op", op, 1);
        chk("R3 prog addr", op_addr, c * 5 + 1);
        chk("R3 prog data", op_data, c ^ 'h5A);
        chk("R10 prog status", rd_sel, 1);
      end else if (c == 'h20) begin
        wr(7, 8'h00);
        chk("R5 erase mismatch", start, 0);
      end
      wr(0, 8'h70);
      chk("R5 R8 idle after", rd_sel, (c == 'h90 || c == 'h98) ? 2 : 1);
    end

    // sweep every byte while busy
    for (int c = 0; c < 256; c++) begin
      busy = 1'b0;
      wr(0, 8'hFF);
      busy = 1'b1;
      wr(0, 8'(c));
      chk("R11 busy rd_sel", rd_sel, c == 'h70 ? 1 : 0);
      chk("R11 busy suspend", susp, c == 'hB0);
      chk("R11 busy start", start, 0);
      chk("R11 busy clr", clr, 0);
      busy = 1'b0;
      if (c == 'hB0) begin
        wr(0, 8'hD0);
        chk("R12 resume pulse", res, 1);
        chk("R12 resume status", rd_sel, 1);
      end
    end

    // read steering and signature stickiness
    wr(0, 8'hFF);
    chk("R1 array data", rd_data, arr_d);
    wr(0, 8'h70);
    chk("R1 status data", rd_data, stat_d);
    wr(0, 8'h90);
    sig_idx = 1'b0; #1;
    chk("R2 mfr code", rd_data, MFR);
    sig_idx = 1'b1; #1;
    chk("R2 dev code", rd_data, DEV);
    wr(0, 8'h20); wr(9, 8'hD0);
    chk("R2 sig ignores erase", start, 0);
    wr(0, 8'h70);
    chk("R2 sig ignores status", rd_sel, 2);
    wr(0, 8'hFF);
    chk("R2 FF leaves sig", rd_sel, 0);

    // erases
    wr(0, 8'h20); wr(20'h1234, 8'hD0);
    chk("R4 block start", start, 1);
    chk("R4 block op", op, 2);
    chk("R4 block addr", op_addr, 20'h1234);
    mux = 1'b1;
    wr(0, 8'h80); wr(3, 8'h10);
    chk("R4 chip start", start, 1);
    chk("R4 chip op", op, 3);
    wr(0, 8'h60);
    chk("R10 reserved keeps status", rd_sel, 1);
    wr(0, 8'h80); wr(0, 8'h20);
    chk("R5 chip mismatch", start, 0);
    wr(0, 8'hFF);
    chk("R5 idle after mismatch", rd_sel, 0);

    // quad program over many groups
    for (int b = 0; b < 40; b++) begin
      logic [AW-1:0] base;
      logic [31:0] word;
      base = AW'(b * 1028);
      word = '0;
      wr(0, 8'h30);
      for (int k = 0; k < 4; k++) begin
        logic [7:0] d;
        d = 8'(b * 37 + k * 11);
        word[8*k +: 8] = d;
        wr(base + AW'(k), d);
        if (k < 3) chk("R6 quad no early start", start, 0);
      end
      chk("R6 quad start", start, 1);
      chk("R6 quad op", op, 4);
      chk("R6 quad addr", op_addr, base);
      chk("R6 quad data", op_data, word);
      chk("R7 quad no err", serr, 0);
    end

    // quad with a bad address at each position
    for (int p = 0; p < 4; p++) begin
      logic [AW-1:0] base;
      base = AW'(16 * (p + 1));
      wr(0, 8'h30);
      for (int k = 0; k < 4; k++) begin
        logic [AW-1:0] a;
        a = base + AW'(k);
        if (k == p) a = (p == 0) ? base + 1 : a + 4;
        wr(a, 8'h00);
      end
      chk("R7 bad quad no start", start, 0);
      chk("R7 bad quad err", serr, 1);
      wr(0, 8'hFF);
      chk("R7 err sticky", serr, 1);
      wr(0, 8'h50);
      chk("R7 err cleared", serr, 0);
      chk("R9 clr pulse", clr, 1);
    end

    // mux gating of quad and chip erase
    mux = 1'b0;
    wr(0, 8'h30);
    for (int k = 0; k < 4; k++) wr(AW'(k), 8'h00);
    chk("R8 quad gated", start, 0);
    chk("R8 quad gated err", serr, 0);
    wr(0, 8'h80); wr(0, 8'h10);
    chk("R8 chip gated", start, 0);
    wr(5, 8'h22);
    chk("R8 10h became program", start, 1);

    // suspension rules
    mux = 1'b1;
    busy = 1'b1; wr(0, 8'hB0); busy = 1'b0;
    chk("R11 suspend", susp, 1);
    wr(0, 8'h20); wr(0, 8'hD0);
    chk("R12 erase blocked", start, 0);
    chk("R12 D0 resumes", res, 1);
    busy = 1'b1; wr(0, 8'hB0); busy = 1'b0;
    wr(0, 8'h30); wr(0, 8'h00);
    chk("R12 quad blocked", start, 0);
    wr(0, 8'h40); wr(20'h77, 8'h5A);
    chk("R12 prog in suspend", start, 1);
    chk("R12 prog data", op_data, 8'h5A);
    wr(0, 8'hD0);
    chk("R12 resume after prog", res, 1);
    wr(0, 8'hD0);
    chk("R12 D0 not suspended", res, 0);
    wr(0, 8'h90);
    chk("R10 leaves status", rd_sel, 2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule